// File: doc/BRIEF.md
# Phase-to-Quadrature Sine/Cosine Generator

This block turns a fractional phase word into the complex exponential e^(j·2π·phase). Its output is one word that holds the sine (quadrature) part and the cosine (in-phase) part side by side. Phase words arrive on a stream slave port with valid, ready, a last flag and a one-bit user flag. Results leave on a matching stream master port, and each sample carries the flags of the phase it was computed from.

The values come from a quarter-wave sine table that is computed when the design elaborates. The table is mirrored and negated according to the quadrant of the phase. The cosine lane reuses the same scheme with the phase moved forward by a quarter turn.

The pipeline is three register stages deep and supports backpressure from the output side. Each stage advances on its own whenever the stage after it can accept data, so an accepted phase always drains out without any further input.

Top module: `qsin_gen`

## Requirements
- R1: The phase input is a 24-bit unsigned fraction of a full turn. Only bits [23:12] are used, as k = phase[23:12]. Bits [11:0] have no effect on the result.
- R2: The sine value is round(16384·sin(2π·k/4096)) and sits in output bits [31:16]. The cosine value is round(16384·cos(2π·k/4096)) and sits in bits [15:0]. Both are signed two's complement numbers with 14 fractional bits. Rounding is to nearest, with ties away from zero.
- R3: Each output half is clamped to the range −16383 to +16383.
- R4: The cardinal phases give exact values as {sine, cosine}:
  - phase 0 gives {0, 16383}
  - phase 0x400000 gives {16383, 0}
  - phase 0x800000 gives {0, −16383}
  - phase 0xC00000 gives {−16383, 0}
- R5: With the output ready held high, a phase accepted at one rising edge shows up as a valid output after the second rising edge that follows. No further input is needed for this.
- R6: The last flag given with a phase appears on the output with that phase's sample.
- R7: The user flag given with a phase appears on the output with that phase's sample.
- R8: While the output is valid and not ready, the output valid, data, last and user stay unchanged.
- R9: Samples leave in the order they were accepted. None is dropped and none is duplicated, under any pattern of gaps and stalls.
- R10: With the output ready held high, the block accepts one phase per cycle. When all three stages hold data and the output is stalled, input ready is low.
- R11: Reset is synchronous and active low, and is held for at least two cycles. During reset and right after it, output valid is low. After reset, input ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| s_phase | input | 24 | Phase word, unsigned fraction of a turn |
| s_valid | input | 1 | Phase word is valid |
| s_last | input | 1 | Last flag for this phase |
| s_user | input | 1 | User flag for this phase |
| s_ready | output | 1 | Block can accept a phase this cycle |
| m_data | output | 32 | {sine, cosine}, signed with 14 fractional bits each |
| m_valid | output | 1 | Output sample is valid |
| m_last | output | 1 | Last flag of this sample |
| m_user | output | 1 | User flag of this sample |
| m_ready | input | 1 | Downstream accepts the sample |

## Verification
The main function is first tried on an exhaustive sweep. Every one of the 4096 table phases is sent once with random low bits, random flags, random input gaps and random output stalls. This separates errors in the quadrant mirroring and negation from errors in the table itself, and shows that the truncated bits are really ignored.

Single isolated phases at the four cardinal points and at a phase with only low bits set cover three things:
- the peak value that does not fit in the table
- the exact latency
- draining without further input

A burst sent into a fully stalled output shows when the pipeline fills and whether the held word stays stable. A back-to-back burst with the output always ready shows whether the block keeps full throughput.

// File: rtl/qsin_pkg.sv
// Package: qsin_pkg
// Shared constants and elaboration-time helpers for the sine/cosine
// generator. The functions are used only to build constant tables.
package qsin_pkg;

    localparam real QSIN_PI = 3.14159265358979323846;

    // Sideband flags that travel alongside every sample.
    typedef struct packed {
        logic last;
        logic user;
    } qsin_sb_t;

    // Round to nearest, ties away from zero.
    function automatic int qsin_round(input real x);
        if (x >= 0.0) return int'($floor(x + 0.5));
        else          return -int'($floor(-x + 0.5));
    endfunction

    // Quarter-wave table entry idx of 2**aw, scaled by 2**frac, clamped.
    function automatic int qsin_entry(input int idx, input int aw, input int frac);
        real ang;
        int  v;
        int  lim;
        ang = QSIN_PI * real'(idx) / (2.0 * real'(1 << aw));
        v   = qsin_round(real'(1 << frac) * $sin(ang));
        lim = (1 << frac) - 1;
        if (v > lim) v = lim;
        return v;
    endfunction

endpackage

// File: rtl/qsin_rom.sv
// Module: qsin_rom
// Quarter-wave sine magnitude table with a registered read port.
// The contents are computed at elaboration from AW and FRAC.
// Assumes the caller folds the phase into the first quadrant.
module qsin_rom #(
    parameter int AW   = 10,
    parameter int DW   = 16,
    parameter int FRAC = 14
) (
    input  logic          clk,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    output logic [DW-1:0] q
);
    import qsin_pkg::*;

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] tbl [DEPTH];

    // Constant table contents, one entry per address.
    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        localparam int VAL = qsin_entry(i, AW, FRAC);
        assign tbl[i] = DW'(VAL);
    end

    // Registered lookup; holds while the stage is stalled.
    always_ff @(posedge clk) begin
        if (rd_en) q <= tbl[addr];
    end

endmodule

// File: rtl/qsin_fold.sv
// Module: qsin_fold
// Folds a truncated phase into a quarter-wave table address.
// The top two bits are the quadrant and the rest is the index.
// Odd quadrants mirror the index; the upper half negates the result.
// A mirrored index of zero is the peak, which lies outside the table.
module qsin_fold #(
    parameter int LUT_W = 12
) (
    input  logic [LUT_W-1:0] phase_top,
    output logic [LUT_W-3:0] addr,
    output logic             peak,
    output logic             neg
);
    localparam int AW = LUT_W - 2;

    logic [1:0]    quad;
    logic [AW-1:0] idx;

    assign quad = phase_top[LUT_W-1 -: 2];
    assign idx  = phase_top[AW-1:0];

    // Mirror and sign selection by quadrant.
    always_comb begin
        addr = quad[0] ? (AW'(0) - idx) : idx;
        peak = quad[0] && (idx == '0);
        neg  = quad[1];
    end

endmodule

// File: rtl/qsin_flow.sv
// Module: qsin_flow
// Valid/ready control for a STAGES-deep pipeline. It also carries the sideband.
// Each stage loads when it is empty or when the stage after it loads, so
// bubbles collapse and data drains without further input.
// load[k] is the enable that the data registers of stage k must use.
module qsin_flow #(
    parameter int STAGES = 3,
    parameter int SB_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [SB_W-1:0]   in_sb,
    output logic              in_ready,
    output logic              out_valid,
    output logic [SB_W-1:0]   out_sb,
    input  logic              out_ready,
    output logic [STAGES-1:0] load
);
    logic [STAGES-1:0] vld;
    logic [SB_W-1:0]   sb [STAGES];

    // Load enables, computed from the output side backwards.
    always_comb begin
        load[STAGES-1] = !vld[STAGES-1] || out_ready;
        for (int k = STAGES - 2; k >= 0; k--) begin
            load[k] = !vld[k] || load[k+1];
        end
    end

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        if (k == 0) begin : g_head
            // First stage: capture input valid and sideband.
            always_ff @(posedge clk) begin
                if (!rst_n)       vld[k] <= 1'b0;
                else if (load[k]) vld[k] <= in_valid;
            end
            // First stage sideband register.
            always_ff @(posedge clk) begin
                if (load[k]) sb[k] <= in_sb;
            end
        end else begin : g_body
            // Later stages: take valid from the previous stage.
            always_ff @(posedge clk) begin
                if (!rst_n)       vld[k] <= 1'b0;
                else if (load[k]) vld[k] <= vld[k-1];
            end
            // Later stage sideband register.
            always_ff @(posedge clk) begin
                if (load[k]) sb[k] <= sb[k-1];
            end
        end
    end

    assign in_ready  = load[0];
    assign out_valid = vld[STAGES-1];
    assign out_sb    = sb[STAGES-1];

    // R10: a full pipeline with a stalled output refuses input.
    assert_full_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((&vld) && !out_ready) |-> !in_ready);

    // R8: a stalled output keeps its valid and sideband.
    assert_sb_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_sb)));

endmodule

// File: rtl/qsin_gen.sv
// Module: qsin_gen
// Pipelined sine/cosine generator. It maps a fractional phase to
// {sine, cosine} in signed 2.14 format using a quarter-wave table.
// Pipeline stages:
//   1. fold the phase into a table address
//   2. read the table
//   3. apply the peak value and the sign
// Assumes reset is held low for at least two cycles.
module qsin_gen #(
    parameter int PHASE_W = 24,
    parameter int SAMP_W  = 16,
    parameter int FRAC    = 14,
    parameter int TBL_AW  = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PHASE_W-1:0]    s_phase,
    input  logic                  s_valid,
    input  logic                  s_last,
    input  logic                  s_user,
    output logic                  s_ready,
    output logic [2*SAMP_W-1:0]   m_data,
    output logic                  m_valid,
    output logic                  m_last,
    output logic                  m_user,
    input  logic                  m_ready
);
    import qsin_pkg::*;

    localparam int                 STAGES  = 3;
    localparam int                 LUT_W   = TBL_AW + 2;
    localparam int                 LANES   = 2;
    localparam logic [PHASE_W-1:0] QTR     = PHASE_W'(1) << (PHASE_W - 2);
    localparam logic [SAMP_W-1:0]  PEAK    = SAMP_W'((1 << FRAC) - 1);
    localparam int                 SB_W    = $bits(qsin_sb_t);

    logic [STAGES-1:0]              load;
    qsin_sb_t                       in_sb;
    logic [SB_W-1:0]                out_sb;
    qsin_sb_t                       out_sb_s;
    logic [LANES-1:0][SAMP_W-1:0]   lane_out;

    assign in_sb.last = s_last;
    assign in_sb.user = s_user;

    qsin_flow #(
        .STAGES (STAGES),
        .SB_W   (SB_W)
    ) flow_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (s_valid),
        .in_sb     (in_sb),
        .in_ready  (s_ready),
        .out_valid (m_valid),
        .out_sb    (out_sb),
        .out_ready (m_ready),
        .load      (load)
    );

    // Lane 0 computes sine; lane 1 adds a quarter turn to give cosine.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [PHASE_W-1:0] ph;
        logic [TBL_AW-1:0]  f_addr;
        logic               f_peak;
        logic               f_neg;
        logic [TBL_AW-1:0]  s1_addr;
        logic               s1_peak;
        logic               s1_neg;
        logic               s2_peak;
        logic               s2_neg;
        logic [SAMP_W-1:0]  s2_mag;
        logic [SAMP_W-1:0]  mag;
        logic [SAMP_W-1:0]  s3_val;

        assign ph = s_phase + (l == 0 ? '0 : QTR);

        qsin_fold #(.LUT_W(LUT_W)) fold_i (
            .phase_top (ph[PHASE_W-1 -: LUT_W]),
            .addr      (f_addr),
            .peak      (f_peak),
            .neg       (f_neg)
        );

        // Stage 1: register the folded address and flags.
        always_ff @(posedge clk) begin
            if (load[0]) begin
                s1_addr <= f_addr;
                s1_peak <= f_peak;
                s1_neg  <= f_neg;
            end
        end

        qsin_rom #(.AW(TBL_AW), .DW(SAMP_W), .FRAC(FRAC)) rom_i (
            .clk   (clk),
            .rd_en (load[1]),
            .addr  (s1_addr),
            .q     (s2_mag)
        );

        // Stage 2: carry the flags alongside the table read.
        always_ff @(posedge clk) begin
            if (load[1]) begin
                s2_peak <= s1_peak;
                s2_neg  <= s1_neg;
            end
        end

        assign mag = s2_peak ? PEAK : s2_mag;

        // Stage 3: apply the sign and register the lane output.
        always_ff @(posedge clk) begin
            if (load[2]) s3_val <= s2_neg ? (SAMP_W'(0) - mag) : mag;
        end

        assign lane_out[l] = s3_val;
    end

    assign m_data   = {lane_out[0], lane_out[1]};
    assign out_sb_s = qsin_sb_t'(out_sb);
    assign m_last   = out_sb_s.last;
    assign m_user   = out_sb_s.user;

    // R11: the cycle after a reset cycle has no valid output.
    assert_reset_empty_R11: assert property (@(posedge clk)
        !rst_n |=> !m_valid);

    // R3: both halves stay inside the clamped range.
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> ($signed(m_data[2*SAMP_W-1 -: SAMP_W]) <= $signed(PEAK) &&
                     $signed(m_data[2*SAMP_W-1 -: SAMP_W]) >= -$signed(PEAK) &&
                     $signed(m_data[SAMP_W-1:0]) <= $signed(PEAK) &&
                     $signed(m_data[SAMP_W-1:0]) >= -$signed(PEAK)));

    // R8: a stalled output word does not change.
    assert_data_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> $stable(m_data));

    // R10: an empty pipeline always accepts input.
    assert_empty_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !m_valid && $past(!m_valid) && $past(!m_valid, 2) && $past(rst_n, 2) |-> s_ready);

endmodule

// File: tb/qsin_gen_tb.sv
// Testbench: qsin_gen_tb_top
// Self-checking bench with a scoreboard. Expected values come from the
// sine/cosine formula evaluated in real arithmetic.
module qsin_gen_tb_top;

    localparam real PI     = 3.14159265358979323846;
    localparam int  NPHASE = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] s_phase = '0;
    logic        s_valid = 1'b0;
    logic        s_last = 1'b0;
    logic        s_user = 1'b0;
    logic        s_ready;
    logic [31:0] m_data;
    logic        m_valid;
    logic        m_last;
    logic        m_user;
    logic        m_ready = 1'b0;

    int checks = 0;
    int errors = 0;
    bit sb_on  = 1'b0;
    bit done   = 1'b0;
    logic [33:0] expq [$];
    int pushed = 0;
    int popped = 0;

    always #10 clk = ~clk;

    qsin_gen dut_i (
        .clk(clk), .rst_n(rst_n), .s_phase(s_phase), .s_valid(s_valid),
        .s_last(s_last), .s_user(s_user), .s_ready(s_ready), .m_data(m_data),
        .m_valid(m_valid), .m_last(m_last), .m_user(m_user), .m_ready(m_ready)
    );

    function automatic int rnd(input real x);
        int v;
        if (x >= 0.0) v = int'($floor(x + 0.5));
        else          v = -int'($floor(-x + 0.5));
        if (v > 16383)  v = 16383;
        if (v < -16383) v = -16383;
        return v;
    endfunction

    function automatic logic [31:0] ref_word(input logic [23:0] ph);
        real a;
        int  s;
        int  c;
        a = 2.0 * PI * real'(int'(ph[23:12])) / real'(NPHASE);
        s = rnd(16384.0 * $sin(a));
        c = rnd(16384.0 * $cos(a));
        return {16'(s), 16'(c)};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Scoreboard: record accepts, compare outputs, check stall stability.
    logic [33:0] prev_out;
    bit          prev_stall = 1'b0;
    always @(negedge clk) begin
        #2;
        if (sb_on) begin
            if (prev_stall) begin
                // R8: held output must match the previous cycle.
                check(m_valid && {m_data, m_last, m_user} == prev_out, "R8",
                      "stalled output changed", {m_valid, m_data, m_last, m_user}, {1'b1, prev_out});
            end
            prev_stall = m_valid && !m_ready;
            prev_out   = {m_data, m_last, m_user};
            if (s_valid && s_ready) begin
                expq.push_back({ref_word(s_phase), s_last, s_user});
                pushed++;
            end
            if (m_valid && m_ready) begin
                logic [33:0] e;
                popped++;
                if (expq.size() == 0) begin
                    check(1'b0, "R9", "output with nothing pending", {m_data, m_last, m_user}, 0);
                end else begin
                    e = expq.pop_front();
                    // R2 R6 R7 R9: data and both flags, in order.
                    check({m_data, m_last, m_user} == e, "R2/R6/R7/R9",
                          "sample mismatch", {m_data, m_last, m_user}, e);
                end
            end
        end
    end

    // Send one phase; called at a negedge, returns at a negedge after acceptance.
    task automatic send(input logic [23:0] ph, input logic l, input logic u);
        s_phase = ph; s_last = l; s_user = u; s_valid = 1'b1;
        #1;
        while (!s_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        s_valid = 1'b0;
    endtask

    // Isolated sample: check latency, value and flags, then no duplicate.
    task automatic single(input logic [23:0] ph, input logic l, input logic u,
                          input logic [31:0] exp_word, input string req);
        int cnt;
        @(negedge clk);
        m_ready = 1'b1;
        s_phase = ph; s_last = l; s_user = u; s_valid = 1'b1;
        @(negedge clk);
        s_valid = 1'b0;
        cnt = 1;
        while (!m_valid && cnt < 10) begin
            @(negedge clk);
            cnt++;
        end
        check(cnt == 3, "R5", "latency in edges", cnt, 3);
        check(m_data == exp_word, req, "isolated value", m_data, exp_word);
        check(m_last == l && m_user == u, "R6/R7", "isolated flags", {m_last, m_user}, {l, u});
        @(negedge clk);
        check(!m_valid, "R9", "duplicate after isolated sample", m_valid, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        int acc;
        time t0;
        // R11: reset behaviour.
        repeat (3) @(negedge clk);
        check(!m_valid, "R11", "valid during reset", m_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!m_valid && s_ready, "R11", "state after reset", {m_valid, s_ready}, 2'b01);
        sb_on = 1'b1;

        // R4: cardinal points; R1: low bits ignored.
        single(24'h000000, 1'b1, 1'b0, {16'sd0, 16'sd16383}, "R4");
        single(24'h400000, 1'b0, 1'b1, {16'sd16383, 16'sd0}, "R4");
        single(24'h800000, 1'b1, 1'b1, {16'sd0, -16'sd16383}, "R4");
        single(24'hC00000, 1'b0, 1'b0, {-16'sd16383, 16'sd0}, "R4");
        single(24'h000FFF, 1'b0, 1'b0, {16'sd0, 16'sd16383}, "R1");

        // R10: fill a stalled pipeline.
        @(negedge clk);
        m_ready = 1'b0;
        acc = 0;
        for (int c = 0; c < 6; c++) begin
            s_phase = 24'(acc * 24'h155000); s_last = acc[0]; s_user = acc[1]; s_valid = 1'b1;
            #1;
            if (s_ready) acc++;
            @(negedge clk);
        end
        check(acc == 3, "R10", "accepts into stalled pipe", acc, 3);
        check(!s_ready && m_valid, "R10", "ready low when full", {s_ready, m_valid}, 2'b01);
        s_valid = 1'b0;
        m_ready = 1'b1;
        repeat (6) @(negedge clk);
        check(expq.size() == 0, "R9", "pending after drain", expq.size(), 0);

        // R10: full throughput with output always ready.
        t0 = $time;
        for (int i = 0; i < 8; i++) send(24'(i * 24'h0A3000), 1'b0, 1'b1);
        check(($time - t0) == 160, "R10", "time for 8 back-to-back", $time - t0, 160);
        repeat (5) @(negedge clk);

        // R1 R2 R3: exhaustive sweep with random gaps and stalls.
        fork
            begin
                for (int k = 0; k < NPHASE; k++) begin
                    send({12'(k), 12'($urandom)}, 1'($urandom), 1'($urandom));
                    if ($urandom % 4 == 0) @(negedge clk);
                end
                done = 1'b1;
            end
            begin
                while (!done) begin
                    @(negedge clk);
                    m_ready = ($urandom % 10) < 7;
                end
                m_ready = 1'b1;
            end
        join
        repeat (10) @(negedge clk);
        check(expq.size() == 0 && pushed == popped, "R9", "all samples delivered",
              popped, pushed);
        finish_up();
    end

endmodule